// File: doc/BRIEF.md
# Asynchronous SRAM Byte Write Sequencer

This block is a synchronous bus master that performs single-byte writes into an asynchronous byte-wide static RAM. A system-side requester presents a 15-bit address, an 8-bit data byte and a style select, then holds a request line high. The block accepts the request, latches all three values, and plays out the memory strobes. Chip enable, write enable and output enable are active low. The data-drive enable tells the pad logic when to put the data byte on the bus.

Every timing limit is a parameter in nanoseconds. This covers the strobe pulse width, address and data setup to the ending edge, data and address hold, the address lead before the strobe and the full write cycle time. At elaboration each limit becomes a whole number of clock periods, rounded up. The write begins when the second of the two strobes falls and ends when the first of them rises. In write-enable-controlled style, chip enable opens and closes the access and write enable carries the pulse. In chip-enable-controlled style the two roles are swapped. Output enable stays high throughout.

Top module: `asw_write_master`

## Requirements
- R1: While reset is applied and just after its release, chip enable, write enable and output enable read 1, the data-drive enable reads 0 and ack reads 0.
- R2: Output enable reads 1 on every cycle.
- R3: With `req_ce_mode`=0 (write-enable-controlled), chip enable falls first and write enable falls LEAD cycles later. Write enable rises first and chip enable rises HOLD cycles after it. The two strobes never change in the same cycle.
- R4: With `req_ce_mode`=1 (chip-enable-controlled), the strobe order is mirrored: write enable leads and trails, and chip enable carries the pulse. The strobes again never change in the same cycle.
- R5: Both strobes are low together for exactly ACT cycles. ACT = max(pulse, ceil(addr-setup) - LEAD, ceil(data-setup) - LEAD, 1). The pulse term is ceil(write-enable width) in style 0 and ceil(chip-enable width) in style 1.
- R6: LEAD = max(1, ceil(address-to-strobe)) cycles separate the accept edge (address, data and first strobe all change there) from the second strobe falling.
- R7: After the ending edge, the data-drive enable, address and data are held for HOLD = max(1, ceil(data-hold), ceil(address-hold)) cycles. The enable then drops on the same edge as the trailing strobe rises.
- R8: Address and data on the memory side equal the accepted request values, and they stay unchanged for as long as the data-drive enable is high.
- R9: The data-drive enable is 1 on every cycle in which either strobe is low.
- R10: ack is a single-cycle pulse. It comes SPAN = max(ceil(cycle-time), LEAD+ACT+HOLD) cycles after the accept edge. No request is accepted in the ack cycle, so a request held high is taken one cycle later.
- R11: Changes on `req_addr`, `req_data` and `req_ce_mode` after acceptance do not reach the memory side during that write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Write request, held until ack |
| req_ce_mode | input | 1 | 0: write-enable-controlled, 1: chip-enable-controlled |
| req_addr | input | 15 | Byte address |
| req_data | input | 8 | Byte to write |
| ack | output | 1 | One-cycle completion pulse |
| sram_ce_n | output | 1 | Chip enable, active low |
| sram_we_n | output | 1 | Write enable, active low |
| sram_oe_n | output | 1 | Output enable, active low (kept high) |
| sram_addr | output | 15 | Memory address |
| sram_dout | output | 8 | Memory write data |
| sram_dout_en | output | 1 | Drive enable for the data pads |

## Verification
A phase sequencer in the wrong state, or a timer loaded with the wrong count, shows up on the strobe pins within the same write. Phase lengths and the ack index are measured cycle by cycle against counts the bench derives from the nanosecond limits, so one extra or missing cycle fails that write. A wrongly latched address, data byte or style shows on the first sample after accept. A missing ack block shows as a zero-cycle accept delay on the very next back-to-back request.

// File: rtl/asw_pkg.sv
`timescale 1ns/1ps
package asw_pkg;

  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_LEAD  = 3'd1,
    PH_BOTH  = 3'd2,
    PH_TAIL  = 3'd3,
    PH_RECOV = 3'd4
  } phase_e;

  // Whole clock periods covering a nanosecond limit (ceiling)
  function automatic int unsigned ns_to_cyc(int unsigned ns, int unsigned clk_ns);
    return (ns + clk_ns - 1) / clk_ns;
  endfunction

  function automatic int unsigned umax(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

  function automatic int unsigned usub(int unsigned a, int unsigned b);
    return (a > b) ? (a - b) : 0;
  endfunction

endpackage

// File: rtl/asw_rst_sync.sv
`timescale 1ns/1ps
module asw_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/asw_phase_timer.sv
`timescale 1ns/1ps
module asw_phase_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expire
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = load || (cnt_q != '0);
    cnt_d  = load ? load_val : (cnt_q - ONE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign expire = (cnt_q == ONE);

  AST_LOAD_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> (load_val != '0)); // R5

  AST_EXPIRE_COUNTS_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && (cnt_q > ONE)) |=> (cnt_q == $past(cnt_q) - ONE)); // R6
endmodule

// File: rtl/asw_seq.sv
`timescale 1ns/1ps
module asw_seq
  import asw_pkg::*;
#(
  parameter int CNT_W    = 4,
  parameter int LEAD_CYC = 1,
  parameter int ACT_WE   = 3,
  parameter int ACT_CE   = 3,
  parameter int HOLD_CYC = 1,
  parameter int REC_WE   = 0,
  parameter int REC_CE   = 0
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   req,
  input  logic   req_ce_mode,
  output logic   accept,
  output phase_e phase_d,
  output logic   mode_d,
  output logic   ack
);
  localparam logic [CNT_W-1:0] LEAD_V   = CNT_W'(LEAD_CYC);
  localparam logic [CNT_W-1:0] ACT_WE_V = CNT_W'(ACT_WE);
  localparam logic [CNT_W-1:0] ACT_CE_V = CNT_W'(ACT_CE);
  localparam logic [CNT_W-1:0] HOLD_V   = CNT_W'(HOLD_CYC);
  localparam logic [CNT_W-1:0] REC_WE_V = CNT_W'(REC_WE);
  localparam logic [CNT_W-1:0] REC_CE_V = CNT_W'(REC_CE);

  phase_e           phase_q;
  logic             mode_q;
  logic             ack_q;
  logic             ack_d;
  logic             t_load;
  logic [CNT_W-1:0] t_val;
  logic             t_expire;
  logic [CNT_W-1:0] rec_val;

  asw_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (t_load),
    .load_val (t_val),
    .expire   (t_expire)
  );

  always_comb begin
    accept  = (phase_q == PH_IDLE) && req && !ack_q;
    rec_val = mode_q ? REC_CE_V : REC_WE_V;
    phase_d = phase_q;
    mode_d  = mode_q;
    ack_d   = 1'b0;
    t_load  = 1'b0;
    t_val   = '0;
    unique case (phase_q)
      PH_IDLE: begin
        if (accept) begin
          phase_d = PH_LEAD;
          mode_d  = req_ce_mode;
          t_load  = 1'b1;
          t_val   = LEAD_V;
        end
      end
      PH_LEAD: begin
        if (t_expire) begin
          phase_d = PH_BOTH;
          t_load  = 1'b1;
          t_val   = mode_q ? ACT_CE_V : ACT_WE_V;
        end
      end
      PH_BOTH: begin
        if (t_expire) begin
          phase_d = PH_TAIL;
          t_load  = 1'b1;
          t_val   = HOLD_V;
        end
      end
      PH_TAIL: begin
        if (t_expire) begin
          if (rec_val != '0) begin
            phase_d = PH_RECOV;
            t_load  = 1'b1;
            t_val   = rec_val;
          end else begin
            phase_d = PH_IDLE;
            ack_d   = 1'b1;
          end
        end
      end
      PH_RECOV: begin
        if (t_expire) begin
          phase_d = PH_IDLE;
          ack_d   = 1'b1;
        end
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      mode_q  <= 1'b0;
      ack_q   <= 1'b0;
    end else begin
      phase_q <= phase_d;
      mode_q  <= mode_d;
      ack_q   <= ack_d;
    end
  end

  assign ack = ack_q;

  AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    ack_q |=> !ack_q); // R10

  AST_ACK_IN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    ack_q |-> (phase_q == PH_IDLE)); // R10

  AST_MODE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    ((phase_q != PH_IDLE) && ($past(phase_q) != PH_IDLE)) |-> $stable(mode_q)); // R11
endmodule

// File: rtl/asw_bus_drv.sv
`timescale 1ns/1ps
module asw_bus_drv
  import asw_pkg::*;
#(
  parameter int AW = 15,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          accept,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_data,
  input  phase_e        phase_d,
  input  logic          mode_d,
  output logic          ce_n,
  output logic          we_n,
  output logic [AW-1:0] addr,
  output logic [DW-1:0] dout,
  output logic          dout_en
);
  logic          ce_n_q, we_n_q, en_q;
  logic          ce_n_d, we_n_d, en_d;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q;

  always_comb begin
    ce_n_d = 1'b1;
    we_n_d = 1'b1;
    unique case (phase_d)
      PH_LEAD, PH_TAIL: begin
        // only the non-pulsing strobe is low
        ce_n_d = mode_d;
        we_n_d = ~mode_d;
      end
      PH_BOTH: begin
        ce_n_d = 1'b0;
        we_n_d = 1'b0;
      end
      default: ;
    endcase
    en_d = (phase_d == PH_LEAD) || (phase_d == PH_BOTH) || (phase_d == PH_TAIL);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ce_n_q <= 1'b1;
      we_n_q <= 1'b1;
      en_q   <= 1'b0;
    end else begin
      ce_n_q <= ce_n_d;
      we_n_q <= we_n_d;
      en_q   <= en_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      data_q <= '0;
    end else if (accept) begin
      addr_q <= req_addr;
      data_q <= req_data;
    end
  end

  assign ce_n    = ce_n_q;
  assign we_n    = we_n_q;
  assign dout_en = en_q;
  assign addr    = addr_q;
  assign dout    = data_q;

  AST_NO_JOINT_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ce_n_q) |-> $stable(we_n_q)); // R3

  AST_DRIVE_COVERS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_n_q || !we_n_q) |-> en_q); // R9

  AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && $past(en_q)) |-> $stable(addr_q)); // R8

  AST_DATA_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && $past(en_q)) |-> $stable(data_q)); // R8
endmodule

// File: rtl/asw_write_master.sv
`timescale 1ns/1ps
module asw_write_master
  import asw_pkg::*;
#(
  parameter int AW          = 15,
  parameter int DW          = 8,
  parameter int CLK_NS      = 20,
  parameter int T_CYCLE_NS  = 70,
  parameter int T_LEAD_NS   = 0,
  parameter int T_WE_PW_NS  = 50,
  parameter int T_CE_PW_NS  = 55,
  parameter int T_DSU_NS    = 30,
  parameter int T_DHOLD_NS  = 5,
  parameter int T_ASU_NS    = 60,
  parameter int T_AHOLD_NS  = 0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic          req_ce_mode,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_data,
  output logic          ack,
  output logic          sram_ce_n,
  output logic          sram_we_n,
  output logic          sram_oe_n,
  output logic [AW-1:0] sram_addr,
  output logic [DW-1:0] sram_dout,
  output logic          sram_dout_en
);
  localparam int unsigned C_LEAD = ns_to_cyc(T_LEAD_NS,  CLK_NS);
  localparam int unsigned C_WPW  = ns_to_cyc(T_WE_PW_NS, CLK_NS);
  localparam int unsigned C_CPW  = ns_to_cyc(T_CE_PW_NS, CLK_NS);
  localparam int unsigned C_DSU  = ns_to_cyc(T_DSU_NS,   CLK_NS);
  localparam int unsigned C_DH   = ns_to_cyc(T_DHOLD_NS, CLK_NS);
  localparam int unsigned C_ASU  = ns_to_cyc(T_ASU_NS,   CLK_NS);
  localparam int unsigned C_AH   = ns_to_cyc(T_AHOLD_NS, CLK_NS);
  localparam int unsigned C_CYC  = ns_to_cyc(T_CYCLE_NS, CLK_NS);

  localparam int unsigned LEAD   = umax(1, C_LEAD);
  localparam int unsigned SU_MIN = umax(1, umax(usub(C_ASU, LEAD), usub(C_DSU, LEAD)));
  localparam int unsigned ACT_WE = umax(C_WPW, SU_MIN);
  localparam int unsigned ACT_CE = umax(C_CPW, SU_MIN);
  localparam int unsigned HOLD   = umax(1, umax(C_DH, C_AH));
  localparam int unsigned REC_WE = usub(C_CYC, LEAD + ACT_WE + HOLD);
  localparam int unsigned REC_CE = usub(C_CYC, LEAD + ACT_CE + HOLD);
  localparam int unsigned MAXC   = umax(umax(LEAD, HOLD),
                                        umax(umax(ACT_WE, ACT_CE), umax(REC_WE, REC_CE)));
  localparam int          CNT_W  = $clog2(MAXC + 1) + 1;

  logic   rst_n_s;
  logic   accept;
  phase_e phase_d;
  logic   mode_d;

  asw_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  asw_seq #(
    .CNT_W    (CNT_W),
    .LEAD_CYC (int'(LEAD)),
    .ACT_WE   (int'(ACT_WE)),
    .ACT_CE   (int'(ACT_CE)),
    .HOLD_CYC (int'(HOLD)),
    .REC_WE   (int'(REC_WE)),
    .REC_CE   (int'(REC_CE))
  ) u_seq (
    .clk         (clk),
    .rst_n       (rst_n_s),
    .req         (req),
    .req_ce_mode (req_ce_mode),
    .accept      (accept),
    .phase_d     (phase_d),
    .mode_d      (mode_d),
    .ack         (ack)
  );

  asw_bus_drv #(.AW(AW), .DW(DW)) u_drv (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .accept   (accept),
    .req_addr (req_addr),
    .req_data (req_data),
    .phase_d  (phase_d),
    .mode_d   (mode_d),
    .ce_n     (sram_ce_n),
    .we_n     (sram_we_n),
    .addr     (sram_addr),
    .dout     (sram_dout),
    .dout_en  (sram_dout_en)
  );

  assign sram_oe_n = 1'b1;

  AST_DRIVE_DROPS_WITH_TRAIL: assert property (@(posedge clk) disable iff (!rst_n_s)
    $fell(sram_dout_en) |-> (sram_ce_n && sram_we_n)); // R7

  AST_ACK_AFTER_RELEASE: assert property (@(posedge clk) disable iff (!rst_n_s)
    ack |-> (sram_ce_n && sram_we_n && !sram_dout_en)); // R10
endmodule

// File: tb/asw_write_master_tb.sv
`timescale 1ns/1ps
module asw_write_master_tb;
  localparam int CLK_NS = 20;
  localparam int T_CYC = 70, T_LD = 0, T_WPW = 50, T_CPW = 55;
  localparam int T_DS = 30, T_DH = 5, T_ASU = 60, T_AH = 0;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 1'b0, req_ce_mode = 1'b0;
  logic [14:0] req_addr = '0;
  logic [7:0]  req_data = '0;
  logic ack, sram_ce_n, sram_we_n, sram_oe_n, sram_dout_en;
  logic [14:0] sram_addr;
  logic [7:0]  sram_dout;

  int total = 0, bad = 0;
  bit done = 1'b0;

  always #(CLK_NS/2) clk = ~clk;

  asw_write_master u_dut (
    .clk(clk), .rst_n(rst_n), .req(req), .req_ce_mode(req_ce_mode),
    .req_addr(req_addr), .req_data(req_data), .ack(ack),
    .sram_ce_n(sram_ce_n), .sram_we_n(sram_we_n), .sram_oe_n(sram_oe_n),
    .sram_addr(sram_addr), .sram_dout(sram_dout), .sram_dout_en(sram_dout_en)
  );

  function automatic int cd(int ns); return (ns + CLK_NS - 1) / CLK_NS; endfunction
  function automatic int mx(int a, int b); return (a > b) ? a : b; endfunction
  function automatic int sb(int a, int b); return (a > b) ? a - b : 0; endfunction
  function automatic int e_lead(); return mx(1, cd(T_LD)); endfunction
  function automatic int e_act(bit m);
    int base = mx(1, mx(sb(cd(T_ASU), e_lead()), sb(cd(T_DS), e_lead())));
    return mx(m ? cd(T_CPW) : cd(T_WPW), base);
  endfunction
  function automatic int e_hold(); return mx(1, mx(cd(T_DH), cd(T_AH))); endfunction
  function automatic int e_span(bit m); return mx(cd(T_CYC), e_lead() + e_act(m) + e_hold()); endfunction

  task automatic chk(bit ok, string rq, string what, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", rq, what, act, exp);
    end
  endtask

  task automatic do_write(logic [14:0] a, logic [7:0] d, bit m, bit keep, bit scr, bit blocked);
    int wait_n = 0, n_lead = 0, n_both = 0, n_tail = 0, ack_at = -1;
    bit order_ok = 1, bus_ok = 1, drv_ok = 1, oe_ok = 1, en_ok = 1, seen_both = 0;
    int L = e_lead(), A = e_act(m), H = e_hold(), S = e_span(m);
    req = 1'b1; req_addr = a; req_data = d; req_ce_mode = m;
    @(negedge clk);
    while (sram_ce_n && sram_we_n && wait_n < 20) begin
      wait_n++;
      @(negedge clk);
    end
    chk(wait_n == (blocked ? 1 : 0), "R10", "accept delay", wait_n, blocked ? 1 : 0);
    for (int k = 0; k < 64; k++) begin
      logic ece, ewe;
      ece = 1'b1; ewe = 1'b1;
      if (k < L || (k >= L + A && k < L + A + H)) begin ece = m; ewe = ~m; end
      else if (k < L + A) begin ece = 1'b0; ewe = 1'b0; end
      if (sram_ce_n !== ece || sram_we_n !== ewe) order_ok = 0;
      if (!sram_ce_n && !sram_we_n) begin n_both++; seen_both = 1; end
      else if (!sram_ce_n || !sram_we_n) begin
        if (seen_both) n_tail++; else n_lead++;
      end
      if ((!sram_ce_n || !sram_we_n) && !sram_dout_en) drv_ok = 0;
      if (sram_dout_en !== (k < L + A + H)) en_ok = 0;
      if (k < L + A + H && (sram_addr !== a || sram_dout !== d)) bus_ok = 0;
      if (sram_oe_n !== 1'b1) oe_ok = 0;
      if (ack) begin
        ack_at = k;
        if (!keep) req = 1'b0;
        break;
      end
      if (scr && k == 1) begin
        req_addr = 15'($urandom); req_data = 8'($urandom); req_ce_mode = ~m;
      end
      @(negedge clk);
    end
    chk(n_lead == L, "R6", "lead cycles", n_lead, L);
    chk(n_both == A, "R5", "both-low cycles", n_both, A);
    chk(n_tail == H && en_ok, "R7", "hold cycles", n_tail, H);
    chk(order_ok, m ? "R4" : "R3", "strobe order", order_ok, 1);
    chk(bus_ok, "R8", "addr/data", {17'd0, sram_addr}, {17'd0, a});
    chk(drv_ok, "R9", "drive covers strobe", drv_ok, 1);
    chk(oe_ok, "R2", "oe high", oe_ok, 1);
    chk(ack_at == S, "R10", "ack index", ack_at, S);
    if (scr) chk(bus_ok && order_ok, "R11", "late input change ignored", bus_ok, 1);
    if (!keep) begin
      @(negedge clk);
      chk(!ack && sram_ce_n && sram_we_n, "R10", "ack single pulse", ack, 0);
    end
  endtask

  initial begin
    #(200000 * CLK_NS);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1a2b3c));
    repeat (3) @(negedge clk);
    chk(sram_ce_n && sram_we_n && sram_oe_n && !sram_dout_en && !ack, "R1", "in reset",
        {sram_ce_n, sram_we_n, sram_oe_n, sram_dout_en, ack}, 5'b11100);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(sram_ce_n && sram_we_n && sram_oe_n && !sram_dout_en && !ack, "R1", "after release",
        {sram_ce_n, sram_we_n, sram_oe_n, sram_dout_en, ack}, 5'b11100);

    // directed corners
    do_write(15'h0000, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0);
    do_write(15'h7fff, 8'hff, 1'b1, 1'b0, 1'b0, 1'b0);
    do_write(15'h5555, 8'ha5, 1'b0, 1'b0, 1'b1, 1'b0);
    do_write(15'h2aaa, 8'h5a, 1'b1, 1'b0, 1'b1, 1'b0);
    // back-to-back with request held
    do_write(15'h1234, 8'h12, 1'b0, 1'b1, 1'b0, 1'b0);
    do_write(15'h4321, 8'h34, 1'b1, 1'b1, 1'b0, 1'b1);
    do_write(15'h0f0f, 8'h56, 1'b0, 1'b0, 1'b0, 1'b1);

    for (int i = 0; i < 40; i++) begin
      int gap = int'($urandom_range(0, 3));
      repeat (gap) @(negedge clk);
      do_write(15'($urandom), 8'($urandom), 1'($urandom), 1'b0, ($urandom_range(0, 3) == 0), 1'b0);
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule